// File: doc/BRIEF.md
# Branch Record Stack

This block keeps a short history of taken branches for performance analysis. Each branch that retires arrives on a strobe with its source address, its destination address and a 3-bit class code. If the branch passes the class filter in the control register, it is pushed into a stack of entries. The newest branch always sits at entry 0. Every older entry moves down by one place, and whatever falls past the active depth is lost. Each entry holds the source, the destination and a 64-bit info word. The info word carries the branch class and the number of cycles since the previous recorded branch.

Software writes the depth register to choose how many entries are live. The same write wipes every entry in one cycle, so an entry 0 source of zero marks a stack that has just been cleared. The control register has a freeze option. When it is set, an interrupt stops all recording until the control register is written again. A combinational read port returns any entry by index. A constant output reports the largest depth the block supports.

Top module: `branch_hist_stack`

## Requirements
- R1: Reset state. After synchronous reset: control reads 0, depth reads MAX_DEPTH (32), frozen is 0, and every entry reads all zero.
- R2: Recording a branch. A branch strobe that is accepted puts a new entry at index 0 one clock later, holding the source, the destination, and the class code zero-extended into info bits 59:56.
- R3: Shifting. On each accepted branch, entry i takes the old value of entry i-1 for every i below the depth. The entry at index depth-1 is dropped.
- R4: Class filter. Control bit 0 is the global enable. Control bit 16+c enables class c: 0 conditional, 1 near jump, 2 call, 3 return, 4 other. A branch is accepted only when the enable bit and its class bit are both 1. Class codes 5 to 7 are never accepted.
- R5: Cycle field. Info bits 15:0 hold the number of clock edges since the previous accepted branch or depth write. Two branches on consecutive cycles give 1. The value saturates at 65535.
- R6: Depth write. A write of 8, 16, 24 or 32 to the depth register (select 1) sets the depth and clears every entry in the same cycle, so entry 0 source reads 0 afterwards. The same write restarts the cycle count.
- R7: Illegal depth write. A depth write of 0, of a value above 32, or of a value that is not a multiple of 8 has no effect: the depth and all entries are kept.
- R8: Freeze. While control bit 1 is set, an interrupt pulse blocks recording from its own cycle onward and sets the frozen output. Any control write (select 0) clears frozen. While bit 1 is clear, the interrupt has no effect.
- R9: Read port. rd_src, rd_dst and rd_info show entry rd_idx combinationally. An index at or above the depth reads zero.
- R10: Capability. depth_cap always reads MAX_DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_valid | input | 1 | Branch retire strobe |
| br_src | input | 48 | Branch source address |
| br_dst | input | 48 | Branch destination address |
| br_kind | input | 3 | Branch class code |
| irq_raise | input | 1 | Interrupt raised pulse |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 control, 1 depth |
| wr_data | input | 32 | Register write data |
| ctrl_rd | output | 32 | Current control register |
| depth_rd | output | 6 | Current depth |
| depth_cap | output | 6 | Maximum supported depth |
| frozen | output | 1 | Recording frozen by interrupt |
| rd_idx | input | 5 | Entry read index |
| rd_src | output | 48 | Source address of selected entry |
| rd_dst | output | 48 | Destination address of selected entry |
| rd_info | output | 64 | Info word of selected entry |

## Verification
The bench pushes nine branches into an 8-deep stack. A design with an off-by-one in the shift would either keep the oldest branch or leave a stale value at index 8 instead of zero. It sends a branch in the same cycle as the interrupt. A design that applies the freeze one cycle late would record that branch. It writes depths of 12, 40 and 0; a design with a loose legality check would take one of them and wipe the stack. The cycle field is checked on back-to-back branches, after a gap, after a depth write, and after more than 65535 idle cycles, which exposes a counter that wraps instead of saturating or that is off by one.

// File: rtl/brhist_pkg.sv
package brhist_pkg;
    localparam int unsigned BR_ADDR_W = 48;
    localparam int unsigned INFO_W    = 64;
    localparam int unsigned CYC_W     = 16;
    localparam int unsigned KIND_W    = 3;
    localparam int unsigned TYPE_W    = 4;
    localparam int unsigned TYPE_LSB  = 56;
    localparam int unsigned NUM_CLASS = 5;
    localparam int unsigned CLASS_LSB = 16;
    localparam int unsigned CTRL_W    = 32;
    localparam int unsigned EN_BIT    = 0;
    localparam int unsigned FRZ_BIT   = 1;

    typedef enum logic [KIND_W-1:0] {
        BK_COND  = 3'd0,
        BK_JUMP  = 3'd1,
        BK_CALL  = 3'd2,
        BK_RET   = 3'd3,
        BK_OTHER = 3'd4
    } br_kind_e;

    typedef struct packed {
        logic [BR_ADDR_W-1:0] src;
        logic [BR_ADDR_W-1:0] dst;
        logic [INFO_W-1:0]    info;
    } br_entry_t;

    function automatic logic [INFO_W-1:0] make_info(input logic [KIND_W-1:0] kind,
                                                   input logic [CYC_W-1:0] cyc);
        logic [INFO_W-1:0] w;
        w = '0;
        w[TYPE_LSB +: TYPE_W] = TYPE_W'(kind);
        w[CYC_W-1:0] = cyc;
        return w;
    endfunction
endpackage

// File: rtl/brhist_gate.sv
module brhist_gate
    import brhist_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl,
    input  logic              irq,
    input  logic              br_valid,
    input  logic [KIND_W-1:0] br_kind,
    output logic              push,
    output logic              frozen
);
    logic frozen_q;
    logic freeze_now;
    logic class_ok;

    always_comb begin
        class_ok   = (32'(br_kind) < NUM_CLASS) && ctrl[CLASS_LSB + 32'(br_kind)];
        freeze_now = ctrl[FRZ_BIT] & irq;
        push       = br_valid & ctrl[EN_BIT] & class_ok & ~frozen_q & ~freeze_now;
    end

    always_ff @(posedge clk) begin
        if (rst)          frozen_q <= 1'b0;
        else if (ctrl_wr) frozen_q <= 1'b0;
        else              frozen_q <= frozen_q | freeze_now;
    end

    assign frozen = frozen_q;

    assert_frozen_blocks_R8: assert property (@(posedge clk) disable iff (rst)
        frozen_q |-> !push);

    assert_freeze_latch_R8: assert property (@(posedge clk) disable iff (rst)
        (freeze_now && !ctrl_wr) |=> frozen_q);
endmodule

// File: rtl/brhist_cyc.sv
module brhist_cyc
    import brhist_pkg::*;
#(
    parameter int unsigned CW = CYC_W
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic          rec,
    output logic [CW-1:0] cyc_field
);
    localparam logic [CW-1:0] SAT = {CW{1'b1}};
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || restart || rec) cnt_q <= '0;
        else if (cnt_q != SAT)     cnt_q <= cnt_q + 1'b1;
    end

    assign cyc_field = (cnt_q == SAT) ? SAT : cnt_q + 1'b1;

    assert_cyc_saturates_R5: assert property (@(posedge clk) disable iff (rst)
        (!rec && !restart && cnt_q == SAT) |=> cnt_q == SAT);

    assert_cyc_restart_R6: assert property (@(posedge clk) disable iff (rst)
        restart |=> cyc_field == CW'(1));
endmodule

// File: rtl/brhist_store.sv
module brhist_store
    import brhist_pkg::*;
#(
    parameter int unsigned MAX_DEPTH = 32,
    localparam int unsigned IDX_W = $clog2(MAX_DEPTH),
    localparam int unsigned DEP_W = $clog2(MAX_DEPTH + 1)
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             push,
    input  logic [DEP_W-1:0] depth,
    input  br_entry_t        new_ent,
    input  logic [IDX_W-1:0] rd_idx,
    output br_entry_t        rd_ent
);
    br_entry_t ent_q [MAX_DEPTH];

    for (genvar i = 0; i < MAX_DEPTH; i++) begin : g_slot
        logic live;
        assign live = DEP_W'(i) < depth;
        if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst || clr)       ent_q[i] <= '0;
                else if (push && live) ent_q[i] <= new_ent;
            end
        end else begin : g_tail
            always_ff @(posedge clk) begin
                if (rst || clr) ent_q[i] <= '0;
                else if (push)  ent_q[i] <= live ? ent_q[i-1] : '0;
            end
        end
    end

    always_comb begin
        if (DEP_W'(rd_idx) < depth) rd_ent = ent_q[rd_idx];
        else                        rd_ent = '0;
    end

    assert_clear_wipes_R6: assert property (@(posedge clk) disable iff (rst)
        clr |=> ent_q[0] == '0);

    assert_newest_first_R2: assert property (@(posedge clk) disable iff (rst)
        (push && !clr) |=> ent_q[0] == $past(new_ent));

    assert_shift_down_R3: assert property (@(posedge clk) disable iff (rst)
        (push && !clr && depth > DEP_W'(1)) |=> ent_q[1] == $past(ent_q[0]));
endmodule

// File: rtl/branch_hist_stack.sv
module branch_hist_stack
    import brhist_pkg::*;
#(
    parameter int unsigned MAX_DEPTH  = 32,
    parameter int unsigned DEPTH_STEP = 8,
    localparam int unsigned IDX_W = $clog2(MAX_DEPTH),
    localparam int unsigned DEP_W = $clog2(MAX_DEPTH + 1)
)(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 br_valid,
    input  logic [BR_ADDR_W-1:0] br_src,
    input  logic [BR_ADDR_W-1:0] br_dst,
    input  logic [KIND_W-1:0]    br_kind,
    input  logic                 irq_raise,
    input  logic                 wr_en,
    input  logic                 wr_sel,
    input  logic [CTRL_W-1:0]    wr_data,
    output logic [CTRL_W-1:0]    ctrl_rd,
    output logic [DEP_W-1:0]     depth_rd,
    output logic [DEP_W-1:0]     depth_cap,
    output logic                 frozen,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic [BR_ADDR_W-1:0] rd_src,
    output logic [BR_ADDR_W-1:0] rd_dst,
    output logic [INFO_W-1:0]    rd_info
);
    localparam logic [DEP_W-1:0] MAX_D = DEP_W'(MAX_DEPTH);

    logic [CTRL_W-1:0] ctrl_q;
    logic [DEP_W-1:0]  depth_q;
    logic              ctrl_wr, depth_wr, depth_ok;
    logic              push;
    logic [CYC_W-1:0]  cyc_field;
    br_entry_t         new_ent, rd_ent;

    always_comb begin
        ctrl_wr  = wr_en && !wr_sel;
        depth_ok = (wr_data != '0) && (wr_data <= CTRL_W'(MAX_DEPTH)) &&
                   (wr_data % CTRL_W'(DEPTH_STEP) == '0);
        depth_wr = wr_en && wr_sel && depth_ok;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            depth_q <= MAX_D;
        end else begin
            if (ctrl_wr)  ctrl_q  <= wr_data;
            if (depth_wr) depth_q <= DEP_W'(wr_data);
        end
    end

    brhist_gate u_gate (
        .clk      (clk),
        .rst      (rst),
        .ctrl_wr  (ctrl_wr),
        .ctrl     (ctrl_q),
        .irq      (irq_raise),
        .br_valid (br_valid),
        .br_kind  (br_kind),
        .push     (push),
        .frozen   (frozen)
    );

    brhist_cyc #(.CW(CYC_W)) u_cyc (
        .clk       (clk),
        .rst       (rst),
        .restart   (depth_wr),
        .rec       (push),
        .cyc_field (cyc_field)
    );

    always_comb begin
        new_ent.src  = br_src;
        new_ent.dst  = br_dst;
        new_ent.info = make_info(br_kind, cyc_field);
    end

    brhist_store #(.MAX_DEPTH(MAX_DEPTH)) u_store (
        .clk     (clk),
        .rst     (rst),
        .clr     (depth_wr),
        .push    (push),
        .depth   (depth_q),
        .new_ent (new_ent),
        .rd_idx  (rd_idx),
        .rd_ent  (rd_ent)
    );

    assign ctrl_rd   = ctrl_q;
    assign depth_rd  = depth_q;
    assign depth_cap = MAX_D;
    assign rd_src    = rd_ent.src;
    assign rd_dst    = rd_ent.dst;
    assign rd_info   = rd_ent.info;

    assert_depth_legal_R7: assert property (@(posedge clk) disable iff (rst)
        depth_q != '0 && depth_q <= MAX_D && (32'(depth_q) % DEPTH_STEP) == 0);

    assert_push_needs_class_R4: assert property (@(posedge clk) disable iff (rst)
        push |-> (ctrl_q[EN_BIT] && 32'(br_kind) < NUM_CLASS &&
                  ctrl_q[CLASS_LSB + 32'(br_kind)]));

    assert_bad_depth_kept_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel && !depth_ok) |=> $stable(depth_q));
endmodule

// File: tb/branch_hist_stack_tb_top.sv
module branch_hist_stack_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        br_valid = 1'b0;
    logic [47:0] br_src = '0, br_dst = '0;
    logic [2:0]  br_kind = '0;
    logic        irq_raise = 1'b0;
    logic        wr_en = 1'b0, wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] ctrl_rd;
    logic [5:0]  depth_rd, depth_cap;
    logic        frozen;
    logic [4:0]  rd_idx = '0;
    logic [47:0] rd_src, rd_dst;
    logic [63:0] rd_info;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    branch_hist_stack dut_i (
        .clk(clk), .rst(rst), .br_valid(br_valid), .br_src(br_src), .br_dst(br_dst),
        .br_kind(br_kind), .irq_raise(irq_raise), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .ctrl_rd(ctrl_rd), .depth_rd(depth_rd), .depth_cap(depth_cap),
        .frozen(frozen), .rd_idx(rd_idx), .rd_src(rd_src), .rd_dst(rd_dst), .rd_info(rd_info)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [31:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic br(input logic [47:0] s, input logic [47:0] d, input logic [2:0] k,
                      input logic irq = 1'b0);
        br_valid = 1'b1; br_src = s; br_dst = d; br_kind = k; irq_raise = irq;
        @(negedge clk);
        br_valid = 1'b0; irq_raise = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic peek(input logic [4:0] idx);
        rd_idx = idx;
        #1;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        idle(3);
        rst = 1'b0;
        idle(1);
        chk("R1", "ctrl", 64'(ctrl_rd), 64'h0);
        chk("R1", "depth", 64'(depth_rd), 64'd32);
        chk("R1", "frozen", 64'(frozen), 64'h0);
        chk("R10", "cap", 64'(depth_cap), 64'd32);
        peek(0);  chk("R1", "e0 src", 64'(rd_src), 64'h0);
        chk("R1", "e0 info", rd_info, 64'h0);
        peek(31); chk("R1", "e31 dst", 64'(rd_dst), 64'h0);
    endtask

    task automatic t_record;
        wr(1'b0, 32'h001F_0001);
        br(48'h1000, 48'h2000, 3'd2);
        br(48'h3000, 48'h4000, 3'd3);
        peek(0);
        chk("R2", "e0 src", 64'(rd_src), 64'h3000);
        chk("R2", "e0 dst", 64'(rd_dst), 64'h4000);
        chk("R2", "e0 type", 64'(rd_info[59:56]), 64'd3);
        chk("R5", "back-to-back cycles", 64'(rd_info[15:0]), 64'd1);
        peek(1);
        chk("R3", "e1 src", 64'(rd_src), 64'h1000);
        chk("R3", "e1 type", 64'(rd_info[59:56]), 64'd2);
    endtask

    task automatic t_filter;
        wr(1'b0, 32'h0001_0001);
        br(48'h5000, 48'h5100, 3'd3);
        peek(0); chk("R4", "masked return kept out", 64'(rd_src), 64'h3000);
        br(48'h6000, 48'h6100, 3'd0);
        peek(0); chk("R4", "conditional taken", 64'(rd_src), 64'h6000);
        wr(1'b0, 32'h00FF_0001);
        br(48'h7000, 48'h7100, 3'd6);
        peek(0); chk("R4", "class 6 rejected", 64'(rd_src), 64'h6000);
        wr(1'b0, 32'h001F_0000);
        br(48'h8000, 48'h8100, 3'd1);
        peek(0); chk("R4", "global enable off", 64'(rd_src), 64'h6000);
    endtask

    task automatic t_depth;
        wr(1'b1, 32'd8);
        chk("R6", "depth 8", 64'(depth_rd), 64'd8);
        peek(0); chk("R6", "wipe src", 64'(rd_src), 64'h0);
        chk("R6", "wipe info", rd_info, 64'h0);
        peek(1); chk("R6", "wipe e1", 64'(rd_src), 64'h0);
        wr(1'b0, 32'h001F_0001);
        br(48'h100, 48'h200, 3'd1);
        wr(1'b1, 32'd12);
        wr(1'b1, 32'd40);
        wr(1'b1, 32'd0);
        chk("R7", "depth kept", 64'(depth_rd), 64'd8);
        peek(0); chk("R7", "entry kept", 64'(rd_src), 64'h100);
        for (int k = 1; k <= 8; k++) br(48'h100 + 48'(k * 16), 48'h200, 3'd1);
        peek(0); chk("R3", "newest", 64'(rd_src), 64'h180);
        peek(7); chk("R3", "last live", 64'(rd_src), 64'h110);
        peek(8); chk("R9", "beyond depth", 64'(rd_src), 64'h0);
        wr(1'b1, 32'd16);
        chk("R6", "depth 16", 64'(depth_rd), 64'd16);
        idle(3);
        br(48'hD00, 48'hD10, 3'd4);
        peek(0); chk("R6", "cycles after depth write", 64'(rd_info[15:0]), 64'd4);
        peek(1); chk("R6", "old entry gone", 64'(rd_src), 64'h0);
    endtask

    task automatic t_cycles;
        br(48'hE00, 48'hE10, 3'd0);
        idle(5);
        br(48'hE20, 48'hE30, 3'd0);
        peek(0); chk("R5", "gap of 6", 64'(rd_info[15:0]), 64'd6);
        idle(70000);
        br(48'hE40, 48'hE50, 3'd1);
        peek(0); chk("R5", "saturated", 64'(rd_info[15:0]), 64'd65535);
        br(48'hE60, 48'hE70, 3'd2);
        peek(0); chk("R5", "after saturation", 64'(rd_info[15:0]), 64'd1);
    endtask

    task automatic t_freeze;
        wr(1'b0, 32'h001F_0003);
        br(48'h900, 48'h910, 3'd1, 1'b1);
        peek(0); chk("R8", "same-cycle branch dropped", 64'(rd_src), 64'hE60);
        chk("R8", "frozen set", 64'(frozen), 64'h1);
        br(48'hA00, 48'hA10, 3'd1);
        peek(0); chk("R8", "frozen drops", 64'(rd_src), 64'hE60);
        wr(1'b0, 32'h001F_0003);
        chk("R8", "frozen cleared", 64'(frozen), 64'h0);
        br(48'hB00, 48'hB10, 3'd1);
        peek(0); chk("R8", "records after unfreeze", 64'(rd_src), 64'hB00);
        wr(1'b0, 32'h001F_0001);
        br(48'hC00, 48'hC10, 3'd1, 1'b1);
        peek(0); chk("R8", "irq ignored without option", 64'(rd_src), 64'hC00);
        chk("R8", "not frozen", 64'(frozen), 64'h0);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_record();
        t_filter();
        t_depth();
        t_cycles();
        t_freeze();
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end
endmodule